// File: doc/BRIEF.md
# Stack Pointer Unit with Call-Frame Record

This block holds the stack pointer of an 8-bit processor core whose data space is 256 bytes. The stack may sit anywhere in that space and grows upward: the pointer always names the most recently filled byte. On each cycle the core raises at most one meaningful strobe. The strobes are push, pop, explicit pointer increment, explicit pointer decrement, call, return, and a direct load of a new pointer value. The block updates the pointer and drives the data-memory address for the access in progress. The memory itself and the instruction decoder sit outside the block.

Next to the pointer, a 32-bit record register keeps a trace of the stack traffic for a debugger. Data bytes enter the record as 0 bits. A call enters two 1 bits, one for each return-address byte. Pops and returns shift the bits back out. A 6-bit occupancy count tracks how many record bits are valid. Two sticky flags report when the record is overfilled or drained past empty. Both flags can be read while the core runs, and a clear strobe resets them.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x07, the record is all zeros, the occupancy count is 0 and both flags are low.
- R2: During a push strobe `addr_o` equals pointer+1. After the edge the pointer is one higher, a 0 has entered the record at bit 0 with older bits moving toward bit 31, and the count has risen by one.
- R3: During a pop strobe `addr_o` equals the pointer. After the edge the pointer is one lower, the record has shifted one place toward bit 0 with a 0 entering at bit 31, and the count has fallen by one.
- R4: An explicit increment or decrement moves the pointer by one and changes the record and count exactly as a push or pop does. `addr_o` equals the pointer during the strobe.
- R5: During a call strobe `addr_o` equals pointer+1. After the edge the pointer is two higher, the record has shifted two places toward bit 31 with bits [1:0] = 2'b11, and the count has risen by two.
- R6: During a return strobe `addr_o` equals the pointer. After the edge the pointer is two lower, the record has shifted two places toward bit 0, and the count has fallen by two.
- R7: The pointer wraps modulo 256 in both directions without any other effect.
- R8: An operation that would take the count above 32 sets the overflow flag and leaves the count at 32. The record shift still happens, and the oldest bits are lost.
- R9: An operation that removes more bits than the count holds sets the underflow flag and leaves the count at 0. The record shift still happens.
- R10: Both flags stay set until `flag_clr_i` is high. If a clear and a new flag event fall in the same cycle, the flag ends up set.
- R11: A direct write loads `wr_data_i` into the pointer and leaves the record and count unchanged. It overrides every other strobe in that cycle.
- R12: When several stack strobes are high together, only one operation takes effect, chosen in this order: call, return, push, pop, increment, decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Data push strobe |
| pop_i | input | 1 | Data pop strobe |
| inc_i | input | 1 | Explicit pointer increment strobe |
| dec_i | input | 1 | Explicit pointer decrement strobe |
| call_i | input | 1 | Call strobe (two-byte return address) |
| ret_i | input | 1 | Return strobe |
| wr_en_i | input | 1 | Direct pointer load strobe |
| wr_data_i | input | 8 | Value for the direct pointer load |
| flag_clr_i | input | 1 | Clears both sticky flags |
| sp_o | output | 8 | Current stack pointer |
| addr_o | output | 8 | Data-memory address of the access in this cycle |
| rec_o | output | 32 | Record register, newest bit at bit 0 |
| rec_cnt_o | output | 6 | Number of valid record bits, 0 to 32 |
| rec_ovf_o | output | 1 | Sticky record overflow flag |
| rec_unf_o | output | 1 | Sticky record underflow flag |

## Verification
Short push, pop, increment and decrement runs show that one-bit and two-bit record moves are told apart, and that calls leave a 11 mark that data pushes do not. Loading the pointer to 0xFF and 0xFE before pushes and calls exposes wrap errors in both the pointer and the address. Sixteen calls followed by a push cross the overflow boundary at exactly 32 bits. Sixteen returns followed by a pop, and a return with one valid bit, cross the underflow boundary. Strobe pairs raised together, each pair with a known winner, show whether the priority order is kept, and clear-with-event cycles show whether set wins.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      STK_IDLE  = 3'd0,
      STK_LOAD  = 3'd1,
      STK_CALL  = 3'd2,
      STK_RET   = 3'd3,
      STK_PUSH  = 3'd4,
      STK_POP   = 3'd5,
      STK_INC   = 3'd6,
      STK_DEC   = 3'd7
   } stk_op_e;

   function automatic logic op_grows(stk_op_e op);
      return (op == STK_PUSH) || (op == STK_INC) || (op == STK_CALL);
   endfunction

   function automatic logic op_shrinks(stk_op_e op);
      return (op == STK_POP) || (op == STK_DEC) || (op == STK_RET);
   endfunction

   function automatic logic op_is_frame(stk_op_e op);
      return (op == STK_CALL) || (op == STK_RET);
   endfunction

endpackage

// File: rtl/stk_op_arbiter.sv
module stk_op_arbiter
   import stk_pkg::*;
(
   input  logic    load_i,
   input  logic    call_i,
   input  logic    ret_i,
   input  logic    push_i,
   input  logic    pop_i,
   input  logic    inc_i,
   input  logic    dec_i,
   output stk_op_e op_o
);

   localparam int NREQ = 7;

   logic [NREQ-1:0] req;
   stk_op_e         op_tab [NREQ];

   assign req = {dec_i, inc_i, pop_i, push_i, ret_i, call_i, load_i};

   assign op_tab[0] = STK_LOAD;
   assign op_tab[1] = STK_CALL;
   assign op_tab[2] = STK_RET;
   assign op_tab[3] = STK_PUSH;
   assign op_tab[4] = STK_POP;
   assign op_tab[5] = STK_INC;
   assign op_tab[6] = STK_DEC;

   // lowest index wins: load, call, return, push, pop, increment, decrement
   always_comb begin
      op_o = STK_IDLE;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[i]) op_o = op_tab[i];
      end
   end

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
   import stk_pkg::*;
#(
   parameter int SP_W        = 8,
   parameter int SP_RESET    = 7,
   parameter int FRAME_BYTES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  stk_op_e         op_i,
   input  logic [SP_W-1:0] wr_data_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] addr_o
);

   localparam logic [SP_W-1:0] RST_VAL = SP_W'(SP_RESET);
   localparam logic [SP_W-1:0] ONE     = SP_W'(1);
   localparam logic [SP_W-1:0] FRAME   = SP_W'(FRAME_BYTES);

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_d;
   logic [SP_W-1:0] sp_up1;

   assign sp_up1 = sp_q + ONE;

   always_comb begin
      unique case (op_i)
         STK_LOAD: sp_d = wr_data_i;
         STK_CALL: sp_d = sp_q + FRAME;
         STK_RET:  sp_d = sp_q - FRAME;
         STK_PUSH,
         STK_INC:  sp_d = sp_up1;
         STK_POP,
         STK_DEC:  sp_d = sp_q - ONE;
         default:  sp_d = sp_q;
      endcase
   end

   // writes land above the top byte, reads come from the top byte
   always_comb begin
      unique case (op_i)
         STK_PUSH,
         STK_CALL: addr_o = sp_up1;
         default:  addr_o = sp_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sp_q <= RST_VAL;
      else        sp_q <= sp_d;
   end

   assign sp_o = sp_q;

endmodule

// File: rtl/stk_rec_tracker.sv
module stk_rec_tracker
   import stk_pkg::*;
#(
   parameter int REC_W       = 32,
   parameter int FRAME_BYTES = 2,
   parameter bit CALL_MARK   = 1'b1,
   parameter int CNT_W       = $clog2(REC_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   input  logic             flag_clr_i,
   output logic [REC_W-1:0] rec_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             unf_o
);

   localparam logic [CNT_W-1:0] STEP1  = CNT_W'(1);
   localparam logic [CNT_W-1:0] STEPF  = CNT_W'(FRAME_BYTES);
   localparam logic [CNT_W:0]   FULL   = (CNT_W+1)'(REC_W);
   localparam logic [REC_W-1:0] F_MASK = REC_W'((64'd1 << FRAME_BYTES) - 64'd1);

   logic [REC_W-1:0] rec_q, rec_d, rec_shl, rec_shr, fill;
   logic [REC_W-1:0] call_fill;
   logic [CNT_W-1:0] cnt_q, cnt_d, n_bits;
   logic [CNT_W:0]   cnt_sum;
   logic             grow, shrink, ovf_evt, unf_evt;
   logic             ovf_q, unf_q;

   generate
      if (CALL_MARK) begin : g_mark_ones
         assign call_fill = F_MASK;
      end else begin : g_mark_zeros
         assign call_fill = '0;
      end
   endgenerate

   assign grow    = op_grows(op_i);
   assign shrink  = op_shrinks(op_i);
   assign n_bits  = op_is_frame(op_i) ? STEPF : STEP1;
   assign fill    = (op_i == STK_CALL) ? call_fill : '0;
   assign rec_shl = (rec_q << n_bits) | fill;
   assign rec_shr = rec_q >> n_bits;
   assign cnt_sum = {1'b0, cnt_q} + {1'b0, n_bits};
   assign ovf_evt = grow && (cnt_sum > FULL);
   assign unf_evt = shrink && (cnt_q < n_bits);

   always_comb begin
      rec_d = rec_q;
      cnt_d = cnt_q;
      if (grow) begin
         rec_d = rec_shl;
         cnt_d = ovf_evt ? FULL[CNT_W-1:0] : cnt_sum[CNT_W-1:0];
      end else if (shrink) begin
         rec_d = rec_shr;
         cnt_d = unf_evt ? '0 : (cnt_q - n_bits);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         rec_q <= rec_d;
         cnt_q <= cnt_d;
         ovf_q <= (ovf_q && !flag_clr_i) || ovf_evt;
         unf_q <= (unf_q && !flag_clr_i) || unf_evt;
      end
   end

   assign rec_o = rec_q;
   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import stk_pkg::*;
#(
   parameter int SP_W        = 8,
   parameter int SP_RESET    = 7,
   parameter int REC_W       = 32,
   parameter int FRAME_BYTES = 2,
   parameter bit CALL_MARK   = 1'b1,
   parameter int CNT_W       = $clog2(REC_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             inc_i,
   input  logic             dec_i,
   input  logic             call_i,
   input  logic             ret_i,
   input  logic             wr_en_i,
   input  logic [SP_W-1:0]  wr_data_i,
   input  logic             flag_clr_i,
   output logic [SP_W-1:0]  sp_o,
   output logic [SP_W-1:0]  addr_o,
   output logic [REC_W-1:0] rec_o,
   output logic [CNT_W-1:0] rec_cnt_o,
   output logic             rec_ovf_o,
   output logic             rec_unf_o
);

   generate
      if (SP_W < 2) begin : g_bad_sp_w
         $error("stack_ptr_unit: SP_W must be at least 2");
      end
      if (FRAME_BYTES < 1 || FRAME_BYTES >= REC_W) begin : g_bad_frame
         $error("stack_ptr_unit: FRAME_BYTES must lie in 1..REC_W-1");
      end
      if (SP_RESET < 0 || SP_RESET >= (1 << SP_W)) begin : g_bad_reset
         $error("stack_ptr_unit: SP_RESET outside pointer range");
      end
      if (CNT_W < $clog2(REC_W + 1)) begin : g_bad_cnt
         $error("stack_ptr_unit: CNT_W too narrow for REC_W");
      end
   endgenerate

   stk_op_e op;

   stk_op_arbiter u_arb (
      .load_i (wr_en_i),
      .call_i (call_i),
      .ret_i  (ret_i),
      .push_i (push_i),
      .pop_i  (pop_i),
      .inc_i  (inc_i),
      .dec_i  (dec_i),
      .op_o   (op)
   );

   stk_sp_reg #(
      .SP_W        (SP_W),
      .SP_RESET    (SP_RESET),
      .FRAME_BYTES (FRAME_BYTES)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .wr_data_i (wr_data_i),
      .sp_o      (sp_o),
      .addr_o    (addr_o)
   );

   stk_rec_tracker #(
      .REC_W       (REC_W),
      .FRAME_BYTES (FRAME_BYTES),
      .CALL_MARK   (CALL_MARK),
      .CNT_W       (CNT_W)
   ) u_rec (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .flag_clr_i (flag_clr_i),
      .rec_o      (rec_o),
      .cnt_o      (rec_cnt_o),
      .ovf_o      (rec_ovf_o),
      .unf_o      (rec_unf_o)
   );

endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
   parameter int SP_W  = 8,
   parameter int REC_W = 32,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_i,
   input logic             pop_i,
   input logic             call_i,
   input logic             ret_i,
   input logic             wr_en_i,
   input logic [SP_W-1:0]  wr_data_i,
   input logic             flag_clr_i,
   input logic [SP_W-1:0]  sp_o,
   input logic [SP_W-1:0]  addr_o,
   input logic [REC_W-1:0] rec_o,
   input logic [CNT_W-1:0] rec_cnt_o,
   input logic             rec_ovf_o,
   input logic             rec_unf_o
);

   logic frame_busy;
   assign frame_busy = wr_en_i || call_i || ret_i;

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !frame_busy) |=> (sp_o == $past(sp_o) + 1'b1)); // R2

   AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !frame_busy) |-> (addr_o == sp_o + 1'b1)); // R2

   AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !frame_busy) |-> (addr_o == sp_o)); // R3

   AST_CALL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !wr_en_i) |=> (rec_o[1:0] == 2'b11)); // R5

   AST_LOAD_KEEPS_REC: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (rec_o == $past(rec_o)) && (rec_cnt_o == $past(rec_cnt_o))
                  && (sp_o == $past(wr_data_i))); // R11

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rec_cnt_o <= CNT_W'(REC_W)); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_ovf_o && !flag_clr_i) |=> rec_ovf_o); // R10

   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_unf_o && !flag_clr_i) |=> rec_unf_o); // R10

endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
   .SP_W  (SP_W),
   .REC_W (REC_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .call_i     (call_i),
   .ret_i      (ret_i),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .flag_clr_i (flag_clr_i),
   .sp_o       (sp_o),
   .addr_o     (addr_o),
   .rec_o      (rec_o),
   .rec_cnt_o  (rec_cnt_o),
   .rec_ovf_o  (rec_ovf_o),
   .rec_unf_o  (rec_unf_o)
);

// File: tb/stack_ptr_unit_tb.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 0, pop_i = 0, inc_i = 0, dec_i = 0;
   logic        call_i = 0, ret_i = 0, wr_en_i = 0, flag_clr_i = 0;
   logic [7:0]  wr_data_i = '0;
   logic [7:0]  sp_o, addr_o;
   logic [31:0] rec_o;
   logic [5:0]  rec_cnt_o;
   logic        rec_ovf_o, rec_unf_o;

   always #2 clk = ~clk;

   stack_ptr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .inc_i(inc_i), .dec_i(dec_i), .call_i(call_i), .ret_i(ret_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
      .sp_o(sp_o), .addr_o(addr_o), .rec_o(rec_o), .rec_cnt_o(rec_cnt_o),
      .rec_ovf_o(rec_ovf_o), .rec_unf_o(rec_unf_o)
   );

   typedef struct {
      logic [7:0]  sp;
      logic [31:0] rec;
      logic [5:0]  cnt;
      logic        ovf;
      logic        unf;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   finished = 0;

   logic [7:0]  m_sp;
   logic [31:0] m_rec;
   logic [5:0]  m_cnt;
   logic        m_ovf, m_unf;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_sp = 8'h07; m_rec = '0; m_cnt = '0; m_ovf = 0; m_unf = 0;
   endtask

   task automatic m_grow(input int n, input bit ones);
      m_rec = (m_rec << n) | (ones ? 32'h3 : 32'h0);
      if (int'(m_cnt) + n > 32) begin m_ovf = 1; m_cnt = 6'd32; end
      else m_cnt = 6'(int'(m_cnt) + n);
   endtask

   task automatic m_shrink(input int n);
      m_rec = m_rec >> n;
      if (int'(m_cnt) < n) begin m_unf = 1; m_cnt = '0; end
      else m_cnt = 6'(int'(m_cnt) - n);
   endtask

   // driver: applies strobes at the falling edge, checks the address,
   // queues the state expected after the next rising edge
   task automatic drive(input bit wr, input logic [7:0] d, input bit cl, input bit rt,
                        input bit pu, input bit po, input bit in, input bit de,
                        input bit clr, input string tag);
      logic [7:0] e_addr;
      exp_t e;
      @(negedge clk);
      wr_en_i = wr; wr_data_i = d; call_i = cl; ret_i = rt;
      push_i = pu; pop_i = po; inc_i = in; dec_i = de; flag_clr_i = clr;
      e_addr = m_sp;
      if (clr) begin m_ovf = 0; m_unf = 0; end
      if (wr)      begin m_sp = d; end
      else if (cl) begin e_addr = m_sp + 8'd1; m_sp = m_sp + 8'd2; m_grow(2, 1); end
      else if (rt) begin m_sp = m_sp - 8'd2; m_shrink(2); end
      else if (pu) begin e_addr = m_sp + 8'd1; m_sp = m_sp + 8'd1; m_grow(1, 0); end
      else if (po) begin m_sp = m_sp - 8'd1; m_shrink(1); end
      else if (in) begin m_sp = m_sp + 8'd1; m_grow(1, 0); end
      else if (de) begin m_sp = m_sp - 8'd1; m_shrink(1); end
      #1;
      if (!wr) chk(addr_o == e_addr, tag, "addr_o", 32'(addr_o), 32'(e_addr));
      e.sp = m_sp; e.rec = m_rec; e.cnt = m_cnt; e.ovf = m_ovf; e.unf = m_unf; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: compares the queued expectation after each rising edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(sp_o == e.sp, e.tag, "sp_o", 32'(sp_o), 32'(e.sp));
         chk(rec_o == e.rec, e.tag, "rec_o", rec_o, e.rec);
         chk(rec_cnt_o == e.cnt, e.tag, "rec_cnt_o", 32'(rec_cnt_o), 32'(e.cnt));
         chk(rec_ovf_o == e.ovf, e.tag, "rec_ovf_o", 32'(rec_ovf_o), 32'(e.ovf));
         chk(rec_unf_o == e.unf, e.tag, "rec_unf_o", 32'(rec_unf_o), 32'(e.unf));
      end
   end

   task automatic check_reset_state();
      chk(sp_o == 8'h07, "R1", "sp_o", 32'(sp_o), 32'h07);
      chk(rec_o == 32'h0, "R1", "rec_o", rec_o, 32'h0);
      chk(rec_cnt_o == 6'd0, "R1", "rec_cnt_o", 32'(rec_cnt_o), 32'h0);
      chk(!rec_ovf_o && !rec_unf_o, "R1", "flags", {30'd0, rec_ovf_o, rec_unf_o}, 32'h0);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 0;
      push_i = 0; pop_i = 0; inc_i = 0; dec_i = 0;
      call_i = 0; ret_i = 0; wr_en_i = 0; flag_clr_i = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
      #1;
      check_reset_state();
   endtask

   initial begin
      model_reset();
      apply_reset();

      // R2: three pushes from the reset pointer, addresses 08, 09, 0A
      repeat (3) drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
      // R3: one pop
      drive(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
      // R4: explicit increment then decrement
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0, "R4");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
      // R5 / R6: call then return
      drive(0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
      drive(0, 0, 0, 1, 0, 0, 0, 0, 0, "R6");
      // R11: direct load overriding a push
      drive(1, 8'hFF, 0, 0, 1, 0, 0, 0, 0, "R11");
      // R7: wrap up and down
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
      drive(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
      drive(1, 8'hFE, 0, 0, 0, 0, 0, 0, 0, "R11");
      drive(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
      drive(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
      // R12: strobe pairs with a known winner
      drive(0, 0, 1, 0, 1, 0, 0, 0, 0, "R12");
      drive(0, 0, 0, 1, 0, 1, 0, 0, 0, "R12");
      drive(0, 0, 0, 0, 1, 1, 0, 0, 0, "R12");
      drive(0, 0, 0, 0, 0, 1, 1, 0, 0, "R12");
      drive(0, 0, 0, 0, 0, 0, 1, 1, 0, "R12");
      drive(0, 0, 1, 1, 0, 0, 0, 0, 0, "R12");
      idle("R12");

      // R1: reset in mid-run
      apply_reset();

      // R8: fill to exactly 32 bits, then one more push
      for (int i = 0; i < 16; i++) drive(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
      // R10: sticky, clear, clear with a new overflow
      idle("R10");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      drive(0, 0, 1, 0, 0, 0, 0, 0, 1, "R10");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");

      // R9: drain past empty
      for (int i = 0; i < 16; i++) drive(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9");
      drive(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
      idle("R10");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
      drive(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      // R11: load with data in the record leaves it alone
      drive(0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
      drive(1, 8'h40, 0, 1, 0, 1, 0, 0, 0, "R11");
      idle("R11");
      repeat (3) @(negedge clk);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule